// File: doc/BRIEF.md
# CBC Chaining Decrypt Sequencer

This block runs cipher-block-chaining decryption in place over a fixed parameter buffer. A host loads a 128-bit initial chaining value as four 32-bit words, then pulses `start`. The sequencer walks the buffer one 16-byte block at a time. For each block it reads four words, hands them to an external 128-bit block-decrypt engine together with a 256-bit key, and XORs the engine result with the current chaining value. It then writes the plaintext back over the ciphertext it came from.

The buffer holds 1200 bytes: three 384-byte operand areas followed by a 48-byte parameter area, which gives 75 blocks. Each ciphertext block is held inside the sequencer before it is overwritten, so that it can become the chaining value for the next block. The engine is assumed to be fixed in 256-bit-key decrypt mode. After the last block the sequencer pulses a reset to the engine and then pulses `done`. The cipher, the key derivation and the register decoding of the buffer all sit outside this block.

Top module: `cbc_chain_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `eng_req`, `eng_rst`, `buf_re` and `buf_we` are all low.
- R2: The plaintext of block 0 equals the engine output for ciphertext block 0, XORed with the IV. The IV word written with `iv_sel`=i occupies bits [32i+31:32i].
- R3: For every block b>0, the plaintext equals the engine output XORed with the original ciphertext of block b-1, which is the value read before it was overwritten.
- R4: Block b occupies word addresses 4b to 4b+3. Word w of a block maps to bits [32w+31:32w] of the 128-bit engine data, and the plaintext is written to the same four addresses it was read from.
- R5: `eng_req` stays high, with `eng_din` stable, until the cycle in which `eng_ack` is seen. Only one request is outstanding at a time, and `eng_key` carries `key`.
- R6: One run issues exactly BUF_BYTES/16 engine requests (75 by default) and never addresses a word at or beyond BUF_BYTES/4.
- R7: After the last write, `eng_rst` is high for exactly one cycle. `done` is high for exactly one cycle, in the cycle right after `eng_rst`.
- R8: `start` has no effect while `busy` or `done` is high. The run in progress finishes with its results unchanged, and `done` pulses only once.
- R9: `busy` is high from the cycle after an accepted `start` until `eng_rst` drops, and every buffer access and engine request happens while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| iv_we | input | 1 | IV word write enable |
| iv_sel | input | 2 | IV word index |
| iv_wdata | input | 32 | IV word data |
| key | input | 256 | Decryption key passed to the engine |
| buf_re | output | 1 | Buffer read strobe (data valid next cycle) |
| buf_we | output | 1 | Buffer write strobe |
| buf_addr | output | 9 | Buffer word address |
| buf_wdata | output | 32 | Buffer write data |
| buf_rdata | input | 32 | Buffer read data, one cycle after `buf_re` |
| eng_req | output | 1 | Engine request |
| eng_key | output | 256 | Key to engine |
| eng_din | output | 128 | Ciphertext block to engine |
| eng_ack | input | 1 | Engine result valid |
| eng_dout | input | 128 | Engine result |
| eng_rst | output | 1 | One-cycle engine reset pulse |

## Verification
A wrong chaining register shows up in the buffer contents. If the IV is used where the saved ciphertext belongs, or plaintext is used instead of ciphertext, block 1 onward is corrupted. A wrong word slot corrupts the first block touched. All of this is visible once `done` pulses, about twelve cycles per block into the run. A wrong block counter or state sequence shows directly at the ports: the engine request count, the `eng_rst`/`done` ordering, or an address beyond the buffer is off within the same run. A mishandled `start` restarts the walk over blocks that are already plaintext, and that damages the whole buffer.

// File: rtl/cbc_chain_ctrl.sv
module cbc_chain_ctrl #(
  parameter int BUF_BYTES = 1200,
  localparam int NWORDS = BUF_BYTES / 4,
  localparam int AW = $clog2(NWORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  input  logic          iv_we,
  input  logic [1:0]    iv_sel,
  input  logic [31:0]   iv_wdata,
  input  logic [255:0]  key,
  output logic          buf_re,
  output logic          buf_we,
  output logic [AW-1:0] buf_addr,
  output logic [31:0]   buf_wdata,
  input  logic [31:0]   buf_rdata,
  output logic          eng_req,
  output logic [255:0]  eng_key,
  output logic [127:0]  eng_din,
  input  logic          eng_ack,
  input  logic [127:0]  eng_dout,
  output logic          eng_rst
);
  localparam int NBLK = BUF_BYTES / 16;
  localparam int BW = AW - 2;
  localparam logic [BW-1:0] LAST = BW'(NBLK - 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_REQ, S_WR, S_RST, S_DONE} st_t;

  st_t            st;
  logic [BW-1:0]  blk;
  logic [2:0]     cnt;
  logic [127:0]   iv, chain, ct, res;
  logic [1:0]     rd_slot;

  assign rd_slot   = cnt[1:0] - 2'd1;
  assign busy      = (st == S_RD) || (st == S_REQ) || (st == S_WR) || (st == S_RST);
  assign done      = (st == S_DONE);
  assign eng_req   = (st == S_REQ);
  assign eng_rst   = (st == S_RST);
  assign eng_key   = key;
  assign eng_din   = ct;
  assign buf_re    = (st == S_RD) && !cnt[2];
  assign buf_we    = (st == S_WR);
  assign buf_addr  = {blk, cnt[1:0]};
  assign buf_wdata = res[{cnt[1:0], 5'd0} +: 32];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      blk   <= '0;
      cnt   <= '0;
      iv    <= '0;
      chain <= '0;
      ct    <= '0;
      res   <= '0;
    end else begin
      if (iv_we) iv[{iv_sel, 5'd0} +: 32] <= iv_wdata;
      case (st)
        S_IDLE: if (start) begin
          chain <= iv;
          blk   <= '0;
          cnt   <= '0;
          st    <= S_RD;
        end
        S_RD: begin
          cnt <= cnt + 3'd1;
          if (cnt != 3'd0) ct[{rd_slot, 5'd0} +: 32] <= buf_rdata;
          if (cnt == 3'd4) begin
            cnt <= '0;
            st  <= S_REQ;
          end
        end
        S_REQ: if (eng_ack) begin
          res   <= eng_dout ^ chain;
          chain <= ct;
          st    <= S_WR;
        end
        S_WR: begin
          cnt <= cnt + 3'd1;
          if (cnt == 3'd3) begin
            cnt <= '0;
            if (blk == LAST) st <= S_RST;
            else begin
              blk <= blk + 1'b1;
              st  <= S_RD;
            end
          end
        end
        S_RST:   st <= S_DONE;
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cbc_chain_ctrl_chk.sv
module cbc_chain_ctrl_chk #(
  parameter int NWORDS = 300,
  parameter int AW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          buf_re,
  input logic          buf_we,
  input logic [AW-1:0] buf_addr,
  input logic          eng_req,
  input logic          eng_ack,
  input logic [127:0]  eng_din,
  input logic          eng_rst
);
  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && !eng_ack) |=> (eng_req && $stable(eng_din)));

  assert_rst_then_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rst |=> done);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_addr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_re || buf_we) |-> (int'(buf_addr) < NWORDS));

  assert_port_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({buf_re, buf_we, eng_req, eng_rst, done}));

  assert_activity_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_re || buf_we || eng_req) |-> busy);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

bind cbc_chain_ctrl cbc_chain_ctrl_chk #(.NWORDS(NWORDS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .buf_re(buf_re),
  .buf_we(buf_we), .buf_addr(buf_addr), .eng_req(eng_req), .eng_ack(eng_ack),
  .eng_din(eng_din), .eng_rst(eng_rst));

// File: tb/sim_cbc_chain_ctrl.sv
module sim_cbc_chain_ctrl;
  localparam int NWORDS = 300;
  localparam int NBLK = 75;

  logic clk = 0, rst_n = 0, start = 0, iv_we = 0;
  logic [1:0] iv_sel = 0;
  logic [31:0] iv_wdata = 0;
  logic [255:0] key = 0;
  logic buf_re, buf_we, busy, done, eng_req, eng_rst;
  logic [8:0] buf_addr;
  logic [31:0] buf_wdata, buf_rdata;
  logic [255:0] eng_key;
  logic [127:0] eng_din, eng_dout;
  logic eng_ack;

  always #5 clk = ~clk;

  cbc_chain_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .iv_we(iv_we), .iv_sel(iv_sel), .iv_wdata(iv_wdata), .key(key),
    .buf_re(buf_re), .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .buf_rdata(buf_rdata), .eng_req(eng_req), .eng_key(eng_key), .eng_din(eng_din),
    .eng_ack(eng_ack), .eng_dout(eng_dout), .eng_rst(eng_rst));

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string rq, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [127:0] stub(input logic [127:0] d, input logic [255:0] k);
    return {d[95:0], d[127:96]} ^ k[127:0] ^ k[255:128];
  endfunction

  logic [31:0] mem [NWORDS];
  logic [31:0] expm [NWORDS];
  always @(posedge clk) begin
    if (buf_we) mem[buf_addr] <= buf_wdata;
    if (buf_re) buf_rdata <= mem[buf_addr];
  end

  int lat = 0, ecnt = 0, req_cnt = 0;
  logic [255:0] seen_key;
  initial begin eng_ack = 0; eng_dout = '0; end
  always @(posedge clk) begin
    if (eng_ack) eng_ack <= 0;
    else if (eng_req) begin
      if (ecnt >= lat) begin
        eng_ack <= 1; eng_dout <= stub(eng_din, eng_key);
        seen_key <= eng_key; ecnt <= 0; req_cnt <= req_cnt + 1;
      end else ecnt <= ecnt + 1;
    end
  end

  int cyc = 0, rst_cnt = 0, done_cnt = 0, rst_cyc = 0, done_cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (eng_rst) begin rst_cnt <= rst_cnt + 1; rst_cyc <= cyc; end
    if (done) begin done_cnt <= done_cnt + 1; done_cyc <= cyc; end
  end

  // seed, iv seed, key seed, ack latency
  localparam logic [103:0] VEC [4] = '{
    {32'h0000_1357, 32'hA5A5_0F0F, 32'h1234_5678, 8'd0},
    {32'hDEAD_BEEF, 32'h0000_0000, 32'hFFFF_FFFF, 8'd1},
    {32'h7777_0001, 32'h8000_0001, 32'h0BAD_F00D, 8'd5},
    {32'h0F1E_2D3C, 32'hFFFF_FFFF, 32'h0000_0000, 8'd2}};

  task automatic run(input logic [103:0] v, input bit poke_start);
    logic [127:0] ivv, chain, ctb, ptb;
    for (int i = 0; i < NWORDS; i++) mem[i] = (32'h9E37_79B9 * (i + 1)) ^ v[103:72];
    key = {8{v[39:8] ^ 32'h5A5A_0000}} ^ {v[39:8], 224'h0} ^ 256'h1;
    lat = int'(v[7:0]);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      iv_we = 1; iv_sel = 2'(i); iv_wdata = v[71:40] + 32'(i * 32'h0101_0101);
      ivv[i*32 +: 32] = v[71:40] + 32'(i * 32'h0101_0101);
    end
    @(negedge clk); iv_we = 0;
    chain = ivv;
    for (int b = 0; b < NBLK; b++) begin
      ctb = {mem[4*b+3], mem[4*b+2], mem[4*b+1], mem[4*b]};
      ptb = stub(ctb, key) ^ chain;
      chain = ctb;
      for (int w = 0; w < 4; w++) expm[4*b+w] = ptb[w*32 +: 32];
    end
    req_cnt = 0; rst_cnt = 0; done_cnt = 0;
    start = 1; @(negedge clk); start = 0;
    chk(busy === 1'b1, "R9 busy after start", 256'(busy), 256'd1);
    if (poke_start) begin
      repeat (40) @(negedge clk);
      start = 1; @(negedge clk); start = 0;
    end
    while (!done) @(negedge clk);
    chk(busy === 1'b0, "R9 busy low at done", 256'(busy), 256'd0);
    if (poke_start) start = 1;
    @(negedge clk); start = 0;
    chk(done === 1'b0, "R7 done one cycle", 256'(done), 256'd0);
    repeat (4) @(negedge clk);
    chk(busy === 1'b0 && done_cnt == 1, "R8 single completion, no restart", 256'(done_cnt), 256'd1);
    chk(rst_cnt == 1, "R7 engine reset count", 256'(rst_cnt), 256'd1);
    chk(done_cyc == rst_cyc + 1, "R7 done follows engine reset", 256'(done_cyc), 256'(rst_cyc + 1));
    chk(req_cnt == NBLK, "R6 engine request count", 256'(req_cnt), 256'(NBLK));
    chk(seen_key == key, "R5 engine key", seen_key, key);
    for (int b = 0; b < NBLK; b++) begin
      logic [127:0] a, e;
      a = {mem[4*b+3], mem[4*b+2], mem[4*b+1], mem[4*b]};
      e = {expm[4*b+3], expm[4*b+2], expm[4*b+1], expm[4*b]};
      if (b == 0) chk(a == e, "R2 first block with IV", 256'(a), 256'(e));
      else chk(a == e, "R3 R4 chained block", 256'(a), 256'(e));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, done, eng_req, eng_rst, buf_re, buf_we} === 6'b0, "R1 reset outputs",
        256'({busy, done, eng_req, eng_rst, buf_re, buf_we}), 256'd0);
    rst_n = 1;
    @(negedge clk);
    chk({busy, done, eng_req, buf_re, buf_we} === 5'b0, "R1 idle after reset", 256'(busy), 256'd0);
    for (int v = 0; v < 4; v++) run(VEC[v], 1'b0);
    // R8: start pulsed mid-run and during done
    run(VEC[2], 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule